// File: doc/BRIEF.md
# Byte-Serial IIR Coefficient Store

This block holds the coefficients for one small cascade of IIR filter sections: a number of bands, each with a fixed number of taps. Every coefficient is 30 bits wide. A host on a simple synchronous register bus reaches the whole store through two registers. It loads a byte address into a pointer register and then moves bytes through a single data register. Writes through the data register advance the pointer by one byte, so a run of coefficients can be loaded without rewriting the pointer. Reads leave the pointer where it is, so the host sets the pointer again before each byte it reads back.

The coefficients sit at byte addresses in band-major order, four bytes per coefficient with the least significant byte first. The two top bits of each coefficient's last byte have no storage. The low three bytes of a coefficient are held in a staging area. The coefficient that the filter datapath sees changes only when its most significant byte is written, so the datapath never sees half of an update. A third register holds one enable bit per band. The register block sits at a base address plus the instance number times a stride, so several copies can share one bus. The datapath reads any coefficient at once by band and tap number.

Top module: `iir_coef_bank`

## Requirements
- R1: A synchronous active-high reset clears the pointer, all staged bytes, all committed coefficients and all band enables. After reset, pointer, data and enable reads return 0 and the datapath port returns 0.
- R2: A write to the pointer register (block offset 0) loads bits 6:0 of the written byte and ignores bit 7. A read of the pointer register returns the 7-bit pointer with bit 7 zero.
- R3: A write to the data register (block offset 1) stores the byte at the current pointer and then adds one to the pointer. From 127 the pointer wraps to 0.
- R4: A read of the data register returns the byte at the current pointer and leaves the pointer unchanged. Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read.
- R5: Tap t of band b (both counted from 0) occupies byte addresses (b*5 + t)*4 + k for k = 0..3, where byte k carries bits 8k+7:8k of the coefficient. The datapath port returns the committed coefficient selected by `dp_band` and `dp_tap`.
- R6: Bits 7:6 of byte 3 of a coefficient are discarded on write and read back as 0. Each coefficient therefore keeps 30 bits.
- R7: Writes to bytes 0 to 2 of a coefficient are staged and read back at once through the data register, but they leave the datapath value unchanged. A write to byte 3 commits the staged bytes together with the new top bits in that same cycle.
- R8: Byte addresses 100 to 127 hold no data. Data writes there store nothing but still advance the pointer, and data reads there return 0.
- R9: The band enable register (block offset 2) keeps bits 4:0, where bit n enables band n (counted from 0). Bits 7:5 are ignored on write and read as 0. The kept bits drive `band_en` and change only on a write to this register.
- R10: The register block starts at BASE_ADDR + INST_ID*INST_STRIDE. Accesses to any other bus address change no state, and reads there return 0.
- R11: A `dp_band` of 5 or more, or a `dp_tap` of 5 or more, makes `dp_coef` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | REG_AW (8) | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| dp_band | input | BAND_SEL_W (3) | Datapath band select |
| dp_tap | input | TAP_SEL_W (3) | Datapath tap select |
| dp_coef | output | 30 | Committed coefficient for the selected band and tap |
| band_en | output | NUM_BANDS (5) | Per-band enable bits |

## Verification
The assertions assume that the host never raises `reg_wr` and `reg_rd` in the same cycle. They also assume that every strobe lasts exactly one clock, so each strobe is one access. The bench drives the bus only through single-cycle write and read tasks that wait a full cycle between accesses, so the two strobes never overlap. The datapath selects change only on the falling edge. The pointer checks therefore see one clean access per edge, including the step from 127 back to 0.

// File: rtl/iir_coef_pkg.sv
package iir_coef_pkg;

    localparam int BYTE_W   = 8;
    localparam int PTR_W    = 7;
    localparam int LANES    = 4;
    localparam int LANE_W   = 2;
    localparam int SLOT_W   = PTR_W - LANE_W;
    localparam int COEF_W   = 30;
    localparam int RSVD_W   = LANES * BYTE_W - COEF_W;
    localparam int MSB_KEEP = BYTE_W - RSVD_W;
    localparam int STAGE_W  = (LANES - 1) * BYTE_W;

    localparam int DEF_BANDS = 5;
    localparam int DEF_TAPS  = 5;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PTR  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_BAND = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] slot;
        logic [LANE_W-1:0] lane;
        logic [BYTE_W-1:0] data;
    } lane_wr_t;

    function automatic logic [PTR_W-1:0] byte_addr(input int band, input int tap,
                                                   input int lane, input int taps);
        return PTR_W'((band * taps + tap) * LANES + lane);
    endfunction

endpackage

// File: rtl/iir_band_enable.sv
module iir_band_enable
    import iir_coef_pkg::*;
#(
    parameter int NUM_BANDS = DEF_BANDS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 band_wr,
    input  logic [NUM_BANDS-1:0] band_wdata,
    output logic [NUM_BANDS-1:0] band_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            band_q <= '0;
        end else if (band_wr) begin
            band_q <= band_wdata;
        end
    end

    // R9: enables move only on a write to their register
    assert_band_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !band_wr |=> $stable(band_q));

endmodule

// File: rtl/iir_coef_store.sv
module iir_coef_store
    import iir_coef_pkg::*;
#(
    parameter int NUM_COEFS = DEF_BANDS * DEF_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_wr_t          lane_wr,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [LANE_W-1:0] rd_lane,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic              dp_valid,
    input  logic [SLOT_W-1:0] dp_slot,
    output logic [COEF_W-1:0] dp_coef
);

    localparam logic [SLOT_W:0] SLOT_LIM = (SLOT_W+1)'(NUM_COEFS);
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

    logic [STAGE_W-1:0] stage_q [NUM_COEFS];
    logic [COEF_W-1:0]  coef_q  [NUM_COEFS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_COEFS; s++) begin
                stage_q[s] <= '0;
                coef_q[s]  <= '0;
            end
        end else if (lane_wr.en) begin
            for (int s = 0; s < NUM_COEFS; s++) begin
                if (lane_wr.slot == SLOT_W'(s)) begin
                    if (lane_wr.lane == TOP_LANE) begin
                        coef_q[s] <= {lane_wr.data[MSB_KEEP-1:0], stage_q[s]};
                    end else begin
                        for (int l = 0; l < LANES - 1; l++) begin
                            if (lane_wr.lane == LANE_W'(l)) begin
                                stage_q[s][l*BYTE_W +: BYTE_W] <= lane_wr.data;
                            end
                        end
                    end
                end
            end
        end
    end

    // host readback: staged low bytes, committed top bits, reserved bits zero
    logic                       rd_ok;
    logic [SLOT_W-1:0]          rd_idx;
    logic [LANES*BYTE_W-1:0]    rd_word;

    always_comb begin
        rd_ok   = {1'b0, rd_slot} < SLOT_LIM;
        rd_idx  = rd_ok ? rd_slot : '0;
        rd_word = {{RSVD_W{1'b0}}, coef_q[rd_idx][COEF_W-1 -: MSB_KEEP], stage_q[rd_idx]};
        rd_byte = rd_ok ? rd_word[rd_lane*BYTE_W +: BYTE_W] : '0;
    end

    logic              dp_ok;
    logic [SLOT_W-1:0] dp_idx;

    always_comb begin
        dp_ok   = dp_valid && ({1'b0, dp_slot} < SLOT_LIM);
        dp_idx  = dp_ok ? dp_slot : '0;
        dp_coef = dp_ok ? coef_q[dp_idx] : '0;
    end

    logic [NUM_COEFS*COEF_W-1:0] coef_flat;
    for (genvar g = 0; g < NUM_COEFS; g++) begin : g_flat
        assign coef_flat[g*COEF_W +: COEF_W] = coef_q[g];
    end

    // R7: committed coefficients change only on a top-byte write
    assert_commit_on_msb_R7: assert property (@(posedge clk) disable iff (rst)
        !(lane_wr.en && lane_wr.lane == TOP_LANE) |=> $stable(coef_flat));

endmodule

// File: rtl/iir_coef_regif.sv
module iir_coef_regif
    import iir_coef_pkg::*;
#(
    parameter int REG_AW     = 8,
    parameter int BLOCK_BASE = 0,
    parameter int USED_BYTES = DEF_BANDS * DEF_TAPS * LANES,
    parameter int NUM_BANDS  = DEF_BANDS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    output lane_wr_t             lane_wr,
    output logic [SLOT_W-1:0]    rd_slot,
    output logic [LANE_W-1:0]    rd_lane,
    input  logic [BYTE_W-1:0]    rd_byte,
    output logic                 band_wr,
    input  logic [NUM_BANDS-1:0] band_q
);

    localparam logic [REG_AW-1:0] ADDR_PTR  = REG_AW'(BLOCK_BASE);
    localparam logic [REG_AW-1:0] ADDR_DATA = REG_AW'(BLOCK_BASE + 1);
    localparam logic [REG_AW-1:0] ADDR_BAND = REG_AW'(BLOCK_BASE + 2);
    localparam logic [PTR_W:0]    USED_LIM  = (PTR_W+1)'(USED_BYTES);

    reg_sel_e         sel;
    logic [PTR_W-1:0] ptr_q;
    logic             in_range;

    always_comb begin
        unique case (reg_addr)
            ADDR_PTR:  sel = SEL_PTR;
            ADDR_DATA: sel = SEL_DATA;
            ADDR_BAND: sel = SEL_BAND;
            default:   sel = SEL_NONE;
        endcase
    end

    assign in_range = {1'b0, ptr_q} < USED_LIM;

    always_comb begin
        lane_wr.en   = reg_wr && (sel == SEL_DATA) && in_range;
        lane_wr.slot = ptr_q[PTR_W-1:LANE_W];
        lane_wr.lane = ptr_q[LANE_W-1:0];
        lane_wr.data = reg_wdata;
        rd_slot      = ptr_q[PTR_W-1:LANE_W];
        rd_lane      = ptr_q[LANE_W-1:0];
        band_wr      = reg_wr && (sel == SEL_BAND);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (reg_wr && sel == SEL_PTR) begin
            ptr_q <= reg_wdata[PTR_W-1:0];
        end else if (reg_wr && sel == SEL_DATA) begin
            ptr_q <= ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (sel)
                SEL_PTR:  reg_rdata <= BYTE_W'(ptr_q);
                SEL_DATA: reg_rdata <= in_range ? rd_byte : '0;
                SEL_BAND: reg_rdata <= BYTE_W'(band_q);
                default:  reg_rdata <= '0;
            endcase
        end
    end

    // R4: input convention - one access per cycle
    assert_single_access_R4: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // R2: pointer write keeps low seven bits
    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel == SEL_PTR) |=> ptr_q == $past(reg_wdata[PTR_W-1:0]));

    // R3: data write steps the pointer, wrapping at the top
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sel == SEL_DATA) |=> ptr_q == $past(ptr_q) + PTR_W'(1));

    // R4: reads never move the pointer
    assert_ptr_hold_on_read_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr) |=> $stable(ptr_q));

    // R8: unused byte addresses read as zero
    assert_oob_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && sel == SEL_DATA && !in_range) |=> reg_rdata == '0);

    // R6: reserved top bits of byte 3 read as zero
    assert_rsvd_bits_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && sel == SEL_DATA && ptr_q[LANE_W-1:0] == LANE_W'(LANES - 1))
        |=> reg_rdata[BYTE_W-1 -: RSVD_W] == '0);

endmodule

// File: rtl/iir_coef_bank.sv
module iir_coef_bank
    import iir_coef_pkg::*;
#(
    parameter int NUM_BANDS   = DEF_BANDS,
    parameter int NUM_TAPS    = DEF_TAPS,
    parameter int REG_AW      = 8,
    parameter int BASE_ADDR   = 0,
    parameter int INST_STRIDE = 16,
    parameter int INST_ID     = 0,
    parameter int BAND_SEL_W  = $clog2(NUM_BANDS),
    parameter int TAP_SEL_W   = $clog2(NUM_TAPS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic [BAND_SEL_W-1:0] dp_band,
    input  logic [TAP_SEL_W-1:0]  dp_tap,
    output logic [29:0]           dp_coef,
    output logic [NUM_BANDS-1:0]  band_en
);

    localparam int NUM_COEFS  = NUM_BANDS * NUM_TAPS;
    localparam int USED_BYTES = NUM_COEFS * LANES;
    localparam int BLOCK_BASE = BASE_ADDR + INST_ID * INST_STRIDE;

    lane_wr_t          lane_wr;
    logic [SLOT_W-1:0] rd_slot;
    logic [LANE_W-1:0] rd_lane;
    logic [BYTE_W-1:0] rd_byte;
    logic              band_wr;
    logic              dp_valid;
    logic [SLOT_W-1:0] dp_slot;

    always_comb begin
        dp_valid = (int'(dp_band) < NUM_BANDS) && (int'(dp_tap) < NUM_TAPS);
        dp_slot  = SLOT_W'(int'(dp_band) * NUM_TAPS + int'(dp_tap));
    end

    iir_coef_regif #(
        .REG_AW     (REG_AW),
        .BLOCK_BASE (BLOCK_BASE),
        .USED_BYTES (USED_BYTES),
        .NUM_BANDS  (NUM_BANDS)
    ) u_regif (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lane_wr   (lane_wr),
        .rd_slot   (rd_slot),
        .rd_lane   (rd_lane),
        .rd_byte   (rd_byte),
        .band_wr   (band_wr),
        .band_q    (band_en)
    );

    iir_coef_store #(
        .NUM_COEFS (NUM_COEFS)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .lane_wr  (lane_wr),
        .rd_slot  (rd_slot),
        .rd_lane  (rd_lane),
        .rd_byte  (rd_byte),
        .dp_valid (dp_valid),
        .dp_slot  (dp_slot),
        .dp_coef  (dp_coef)
    );

    iir_band_enable #(
        .NUM_BANDS (NUM_BANDS)
    ) u_band (
        .clk        (clk),
        .rst        (rst),
        .band_wr    (band_wr),
        .band_wdata (reg_wdata[NUM_BANDS-1:0]),
        .band_q     (band_en)
    );

    // R11: an out-of-range selection yields zero
    assert_dp_range_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !dp_valid |-> dp_coef == '0);

endmodule

// File: tb/iir_coef_bank_tb.sv
module iir_coef_bank_tb;

    localparam int INST_ID = 1;
    localparam logic [7:0] A_PTR  = 8'd16;
    localparam logic [7:0] A_DATA = 8'd17;
    localparam logic [7:0] A_BAND = 8'd18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [2:0]  dp_band = '0;
    logic [2:0]  dp_tap = '0;
    logic [29:0] dp_coef;
    logic [4:0]  band_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    iir_coef_bank #(.INST_ID(INST_ID)) u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_band(dp_band),
        .dp_tap(dp_tap), .dp_coef(dp_coef), .band_en(band_en)
    );

    // {band[3:0], tap[3:0], value[31:0]}
    localparam logic [39:0] VEC [6] = '{
        {4'd0, 4'd0, 32'h1234_5678},
        {4'd0, 4'd4, 32'hFFFF_FFFF},
        {4'd2, 4'd1, 32'hC0A5_5A01},
        {4'd4, 4'd4, 32'h8000_0001},
        {4'd1, 4'd3, 32'h3ABC_DEF0},
        {4'd3, 4'd0, 32'h7F00_FF00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] baddr(input int b, input int t, input int k);
        return 8'((b * 5 + t) * 4 + k);
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        logic [7:0] rb2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_read(A_PTR, rb);  check("R1 ptr after reset", rb, 0);
        bus_read(A_BAND, rb); check("R1 band reg after reset", rb, 0);
        bus_read(A_DATA, rb); check("R1 data after reset", rb, 0);
        check("R1 dp_coef after reset", dp_coef, 0);

        // R5 R2 R6: vector table
        for (int i = 0; i < 6; i++) begin
            int b, t;
            logic [31:0] v;
            logic [29:0] expv;
            b = int'(VEC[i][39:36]);
            t = int'(VEC[i][35:32]);
            v = VEC[i][31:0];
            expv = v[29:0];
            bus_write(A_PTR, baddr(b, t, 0) | 8'h80);
            for (int k = 0; k < 4; k++) bus_write(A_DATA, v[k*8 +: 8]);
            bus_read(A_PTR, rb);
            check("R2 R3 ptr after four writes", rb, baddr(b, t, 4));
            @(negedge clk);
            dp_band = 3'(b); dp_tap = 3'(t);
            #1;
            check("R5 R6 dp_coef from table", dp_coef, expv);
            for (int k = 0; k < 4; k++) begin
                logic [7:0] eb;
                eb = (k == 3) ? (v[31:24] & 8'h3F) : v[k*8 +: 8];
                bus_write(A_PTR, baddr(b, t, k));
                bus_read(A_DATA, rb);
                check("R5 R6 byte readback", rb, eb);
            end
        end

        // R4: repeated reads return the same byte, pointer stays
        bus_write(A_PTR, baddr(2, 1, 1));
        bus_read(A_DATA, rb);
        bus_read(A_DATA, rb2);
        check("R4 second read same byte", rb2, 8'h5A);
        bus_read(A_PTR, rb);
        check("R4 ptr unchanged by reads", rb, baddr(2, 1, 1));

        // R7: staged bytes do not reach the datapath until byte 3
        @(negedge clk); dp_band = 3'd1; dp_tap = 3'd0;
        bus_write(A_PTR, baddr(1, 0, 0));
        bus_write(A_DATA, 8'h11);
        bus_write(A_DATA, 8'h22);
        bus_write(A_DATA, 8'h33);
        check("R7 dp unchanged before top byte", dp_coef, 0);
        bus_write(A_PTR, baddr(1, 0, 1));
        bus_read(A_DATA, rb);
        check("R7 staged byte readback", rb, 8'h22);
        bus_write(A_PTR, baddr(1, 0, 3));
        bus_write(A_DATA, 8'hFF);
        check("R7 R6 commit on top byte", dp_coef, 30'h3F33_2211);

        // R8: unused addresses
        bus_write(A_PTR, 8'd100);
        bus_write(A_DATA, 8'hAA);
        bus_read(A_PTR, rb);
        check("R8 ptr advances on unused write", rb, 8'd101);
        bus_write(A_PTR, 8'd100);
        bus_read(A_DATA, rb);
        check("R8 unused read zero", rb, 0);

        // R3: wrap from 127 to 0, top address stores nothing
        bus_write(A_PTR, 8'd127);
        bus_write(A_DATA, 8'h55);
        bus_read(A_PTR, rb);
        check("R3 pointer wrap", rb, 0);
        @(negedge clk); dp_band = 3'd0; dp_tap = 3'd0;
        #1;
        check("R3 R8 coef 0 untouched by wrap", dp_coef, 30'h1234_5678);

        // R9: band enables
        bus_write(A_BAND, 8'hFF);
        check("R9 band_en masks upper bits", band_en, 5'h1F);
        bus_read(A_BAND, rb);
        check("R9 band reg readback", rb, 8'h1F);
        bus_write(A_BAND, 8'h0A);
        check("R9 band_en pattern", band_en, 5'h0A);

        // R10: instance-0 addresses and gaps have no effect
        bus_write(A_PTR, 8'd40);
        bus_write(8'd0, 8'd7);
        bus_write(8'd1, 8'h99);
        bus_write(8'd2, 8'h1F);
        bus_read(A_PTR, rb);
        check("R10 ptr unaffected by foreign address", rb, 8'd40);
        check("R10 band_en unaffected", band_en, 5'h0A);
        bus_read(8'd19, rb);
        check("R10 unmapped read zero", rb, 0);

        // R11: out-of-range datapath select
        @(negedge clk); dp_band = 3'd5; dp_tap = 3'd0;
        #1;
        check("R11 band out of range", dp_coef, 0);
        @(negedge clk); dp_band = 3'd0; dp_tap = 3'd7;
        #1;
        check("R11 tap out of range", dp_coef, 0);

        // R1: reset mid-run clears everything
        @(negedge clk); rst = 1'b1; dp_tap = 3'd0;
        @(negedge clk); rst = 1'b0;
        check("R1 dp_coef cleared", dp_coef, 0);
        check("R1 band_en cleared", band_en, 0);
        bus_read(A_PTR, rb);
        check("R1 ptr cleared", rb, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule